// File: doc/BRIEF.md
# Video DMA Instruction Sequencer

The sequencer executes a short program of two-word instructions that moves captured video bytes into memory. It fetches each instruction through a read port with a fixed latency of one cycle. The first word is the command and the second is an address, which is zero for the sync operations. The sequencer then acts on the instruction. A sync operation drops incoming video until a chosen field begins. A transfer operation writes a counted run of bytes to consecutive byte addresses. A jump moves the fetch pointer.

A scan line begins with a line-start transfer. It may continue through any number of in-line transfers, each aimed at its own memory fragment. Each in-line transfer names the byte position in the line where it resumes, and the sequencer checks that position against its own running line count. Software sets a program start address and raises the run enable. A jump back to a sync-odd instruction forms an idle loop that keeps field lock while the loop drops all input.

Top module: `vdma_seq`

## Requirements
- R1: While `run` is low after reset, `rd_req`, `wr_valid`, `irq`, `err` and `vid_ready` all stay low.
- R2: When `run` is high in the idle state, the fetch pointer loads `start_addr` with bits 1:0 forced to zero. Each instruction is read as two requests, the command at the pointer and the argument at pointer+4, and `rd_data` returns one cycle after each request. A non-jump instruction advances the pointer by 8.
- R3: Command word fields: bit 31 is 1 for a valid instruction; bits 30:28 hold the opcode (0 sync-odd, 1 sync-even, 2 jump, 3 line-start, 4 in-line); bit 27 requests an interrupt; bits 23:12 hold the line byte position; bits 11:0 hold the byte count. Bits 26:24 have no effect.
- R4: Sync-odd accepts and drops every video byte until a valid byte arrives with `vid_odd_start` high. That byte is not consumed and becomes the first byte of the next instruction.
- R5: Sync-even behaves the same way, but ends on `vid_even_start`. Bytes marked as odd starts are dropped while it waits.
- R6: Line-start with count N writes the next N video bytes to addresses A, A+1, …, A+N-1, where A is the argument word. It sets the line position to N.
- R7: In-line behaves like line-start, but only when its position field equals the current line position, which then advances by N. On a mismatch it writes nothing and raises the error.
- R8: Jump loads the fetch pointer from the argument word, with bits 1:0 cleared.
- R9: A command with bit 31 clear, or with an opcode of 5 to 7, halts the sequencer. `err` then stays high with no further reads, writes or accepted bytes until `run` goes low.
- R10: `irq` pulses for one cycle when an instruction with bit 27 set completes. For a transfer of one byte or more, the pulse coincides with the `wr_valid` of its final byte. For any other instruction, it follows one cycle after completion.
- R11: While `vid_valid` is low during a transfer, nothing is written and no byte is lost.
- R12: A transfer with count 0 completes without writing.
- R13: Dropping `run` returns the block to idle from any state within one cycle. This clears `err` and stops all reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Run enable |
| start_addr | input | 32 | Program start byte address |
| rd_req | output | 1 | Instruction word read request |
| rd_addr | output | 32 | Instruction word byte address |
| rd_data | input | 32 | Read data, one cycle after the request |
| vid_data | input | 8 | Video byte |
| vid_valid | input | 1 | Video byte present |
| vid_odd_start | input | 1 | Byte is first of an odd field |
| vid_even_start | input | 1 | Byte is first of an even field |
| vid_ready | output | 1 | Byte accepted this cycle when valid |
| wr_valid | output | 1 | Memory byte write strobe |
| wr_addr | output | 32 | Memory byte address |
| wr_data | output | 8 | Memory byte data |
| irq | output | 1 | Interrupt pulse |
| err | output | 1 | Invalid instruction halt |

## Verification
A byte accepted in cycle t appears on `wr_valid` in cycle t+1. The interrupt of a transfer shares that cycle, and the interrupt of a non-transfer instruction comes one cycle after the cycle in which it completes. The bench samples at the falling edge. It pairs every write strobe with the next entry of an expected queue of address, data and interrupt flag, and it counts any lone interrupt against an expected budget. As a result, a write that is late, extra or missing, or an interrupt that is misplaced, is caught on the cycle it happens. The error and idle conditions are sampled a fixed number of cycles after their cause, which is beyond the three-cycle fetch and decode.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
    localparam int AW    = 32;
    localparam int VW    = 8;
    localparam int FW    = 12;
    localparam int OPW   = 3;
    localparam int STEP  = 8;
    localparam int ARG_OFS = 4;

    localparam logic [OPW-1:0] OP_SYNC_ODD  = 3'd0;
    localparam logic [OPW-1:0] OP_SYNC_EVEN = 3'd1;
    localparam logic [OPW-1:0] OP_JUMP      = 3'd2;
    localparam logic [OPW-1:0] OP_LINE      = 3'd3;
    localparam logic [OPW-1:0] OP_INLINE    = 3'd4;
    localparam logic [OPW-1:0] OP_LAST      = OP_INLINE;

    typedef enum logic [2:0] {
        S_IDLE, S_CMD, S_ARG, S_DEC, S_SYNC, S_XFER, S_HALT
    } st_e;

    typedef struct packed {
        st_e            st;
        logic [AW-1:0]  pc;
        logic [31:0]    cmd;
        logic [AW-1:0]  waddr;
        logic [FW-1:0]  rem;
        logic [FW-1:0]  lpos;
        logic           odd;
        logic           irq_pend;
        logic           wv;
        logic [AW-1:0]  wa;
        logic [VW-1:0]  wd;
        logic           irq;
    } seq_t;
endpackage

// File: rtl/vdma_decode.sv
module vdma_decode
    import vdma_pkg::*;
(
    input  logic [31:0]    cmd,
    output logic           ok,
    output logic [OPW-1:0] op,
    output logic           want_irq,
    output logic [FW-1:0]  pos,
    output logic [FW-1:0]  cnt
);
    always_comb begin
        op       = cmd[30:28];
        want_irq = cmd[27];
        pos      = cmd[23:12];
        cnt      = cmd[11:0];
        ok       = cmd[31] && (cmd[30:28] <= OP_LAST);
    end
endmodule

// File: rtl/vdma_seq.sv
module vdma_seq
    import vdma_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [31:0]   start_addr,
    output logic          rd_req,
    output logic [31:0]   rd_addr,
    input  logic [31:0]   rd_data,
    input  logic [7:0]    vid_data,
    input  logic          vid_valid,
    input  logic          vid_odd_start,
    input  logic          vid_even_start,
    output logic          vid_ready,
    output logic          wr_valid,
    output logic [31:0]   wr_addr,
    output logic [7:0]    wr_data,
    output logic          irq,
    output logic          err
);
    seq_t q, d;

    logic           dec_ok, dec_irq;
    logic [OPW-1:0] dec_op;
    logic [FW-1:0]  dec_pos, dec_cnt;
    logic           marker;

    vdma_decode u_dec (
        .cmd(q.cmd), .ok(dec_ok), .op(dec_op), .want_irq(dec_irq),
        .pos(dec_pos), .cnt(dec_cnt)
    );

    always_comb begin
        d         = q;
        d.wv      = 1'b0;
        d.irq     = 1'b0;
        rd_req    = 1'b0;
        rd_addr   = q.pc;
        vid_ready = 1'b0;
        marker    = q.odd ? vid_odd_start : vid_even_start;
        if (!run) begin
            d.st = S_IDLE;
        end else begin
            case (q.st)
                S_IDLE: begin
                    d.pc = {start_addr[AW-1:2], 2'b00};
                    d.st = S_CMD;
                end
                S_CMD: begin
                    rd_req = 1'b1;
                    d.st   = S_ARG;
                end
                S_ARG: begin
                    rd_req  = 1'b1;
                    rd_addr = q.pc + AW'(ARG_OFS);
                    d.cmd   = rd_data;
                    d.st    = S_DEC;
                end
                S_DEC: begin
                    d.irq_pend = dec_irq;
                    if (!dec_ok) begin
                        d.st = S_HALT;
                    end else if (dec_op == OP_JUMP) begin
                        d.pc  = {rd_data[AW-1:2], 2'b00};
                        d.irq = dec_irq;
                        d.st  = S_CMD;
                    end else if (dec_op == OP_SYNC_ODD || dec_op == OP_SYNC_EVEN) begin
                        d.odd = (dec_op == OP_SYNC_ODD);
                        d.pc  = q.pc + AW'(STEP);
                        d.st  = S_SYNC;
                    end else if (dec_op == OP_INLINE && dec_pos != q.lpos) begin
                        d.st = S_HALT;
                    end else begin
                        d.waddr = rd_data;
                        d.rem   = dec_cnt;
                        d.lpos  = (dec_op == OP_LINE) ? '0 : q.lpos;
                        d.pc    = q.pc + AW'(STEP);
                        if (dec_cnt == '0) begin
                            d.irq = dec_irq;
                            d.st  = S_CMD;
                        end else begin
                            d.st = S_XFER;
                        end
                    end
                end
                S_SYNC: begin
                    vid_ready = !(vid_valid && marker);
                    if (vid_valid && marker) begin
                        d.irq = q.irq_pend;
                        d.st  = S_CMD;
                    end
                end
                S_XFER: begin
                    vid_ready = 1'b1;
                    if (vid_valid) begin
                        d.wv    = 1'b1;
                        d.wa    = q.waddr;
                        d.wd    = vid_data;
                        d.waddr = q.waddr + 1'b1;
                        d.rem   = q.rem - 1'b1;
                        d.lpos  = q.lpos + 1'b1;
                        if (q.rem == FW'(1)) begin
                            d.irq = q.irq_pend;
                            d.st  = S_CMD;
                        end
                    end
                end
                default: d.st = S_HALT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign wr_valid = q.wv;
    assign wr_addr  = q.wa;
    assign wr_data  = q.wd;
    assign irq      = q.irq;
    assign err      = (q.st == S_HALT);

    p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!rd_req && !vid_ready && !wr_valid));
    p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    p_write_has_byte_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(vid_valid && vid_ready));
    p_sync_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_SYNC) |-> !wr_valid);
    p_fetch_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_addr[1:0] == 2'b00));
    p_stop_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!rd_req && !wr_valid && !err));
endmodule

// File: tb/vdma_seq_bench.sv
module vdma_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [31:0] start_addr = '0;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic [31:0] rd_data = '0;
    logic [7:0]  vid_data = '0;
    logic        vid_valid = 1'b0, vid_odd_start = 1'b0, vid_even_start = 1'b0;
    logic        vid_ready, wr_valid, irq, err;
    logic [31:0] wr_addr;
    logic [7:0]  wr_data;

    always #10 clk = ~clk;

    vdma_seq u_vdma_seq (
        .clk(clk), .rst_n(rst_n), .run(run), .start_addr(start_addr),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
        .vid_data(vid_data), .vid_valid(vid_valid), .vid_odd_start(vid_odd_start),
        .vid_even_start(vid_even_start), .vid_ready(vid_ready),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .irq(irq), .err(err)
    );

    int checks = 0, fails = 0, cyc = 0;
    logic [31:0] mem [0:63];
    always @(posedge clk) if (rd_req) rd_data <= mem[rd_addr[7:2]];

    // video source queues
    logic [7:0] vq_d[$];
    logic       vq_o[$], vq_e[$];
    logic       take = 1'b0, gap = 1'b0;
    always @(posedge clk) take <= vid_valid && vid_ready;

    // expected write stream
    logic [31:0] ex_a[$];
    logic [7:0]  ex_d[$];
    logic        ex_i[$];
    int          solo_irq = 0, rd_while_err = 0;
    logic [31:0] first_rd = '1;
    logic        seen_rd = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (take && vq_d.size() > 0) begin
            void'(vq_d.pop_front()); void'(vq_o.pop_front()); void'(vq_e.pop_front());
        end
        if (vq_d.size() > 0 && !(gap && (cyc % 4 == 1))) begin
            vid_valid = 1'b1; vid_data = vq_d[0];
            vid_odd_start = vq_o[0]; vid_even_start = vq_e[0];
        end else begin
            vid_valid = 1'b0; vid_odd_start = 1'b0; vid_even_start = 1'b0;
        end
        if (rst_n) begin
            if (rd_req && !seen_rd) begin seen_rd = 1'b1; first_rd = rd_addr; end
            if (err && rd_req) rd_while_err++;
            if (wr_valid) begin
                if (ex_a.size() == 0) chk(1'b0, "R6/R7 extra write", {wr_addr, 24'd0, wr_data}, 0);
                else begin
                    logic [31:0] ea; logic [7:0] ed; logic ei;
                    ea = ex_a.pop_front(); ed = ex_d.pop_front(); ei = ex_i.pop_front();
                    chk(wr_addr == ea && wr_data == ed, "R6/R7/R11 write", {wr_addr, 24'd0, wr_data}, {ea, 24'd0, ed});
                    chk(irq == ei, "R10 irq on final write", irq, ei);
                end
            end else if (irq) begin
                chk(solo_irq > 0, "R10 lone irq", 1, solo_irq);
                if (solo_irq > 0) solo_irq--;
            end
        end
        if (cyc == 100000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, 100000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    function automatic logic [31:0] ins(input bit v, input int op, input bit i, input int pos, input int cnt);
        return {v, 3'(op), i, 3'd5, 12'(pos), 12'(cnt)};
    endfunction

    task automatic push(input logic [7:0] dv, input bit o, input bit e);
        vq_d.push_back(dv); vq_o.push_back(o); vq_e.push_back(e);
    endtask
    task automatic expw(input logic [31:0] a, input logic [7:0] dv, input bit i);
        ex_a.push_back(a); ex_d.push_back(dv); ex_i.push_back(i);
    endtask
    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic go(input logic [31:0] sa);
        @(negedge clk); start_addr = sa; seen_rd = 1'b0; run = 1'b1;
    endtask
    task automatic stop();
        @(negedge clk); run = 1'b0; wait_cyc(2);
        vq_d.delete(); vq_o.delete(); vq_e.delete();
    endtask

    initial begin
        for (int k = 0; k < 64; k++) mem[k] = '0;
        wait_cyc(3); rst_n = 1'b1; wait_cyc(3);
        // R1 idle state
        chk(!rd_req && !wr_valid && !irq && !err && !vid_ready, "R1 idle outputs",
            {rd_req, wr_valid, irq, err, vid_ready}, 0);

        // Test A: sync-odd, split line, jump loop (R2 R3 R4 R6 R7 R8 R10 R11)
        mem[16] = ins(1, 0, 0, 0, 0);  mem[17] = 0;
        mem[18] = ins(1, 3, 0, 0, 4);  mem[19] = 32'h1000;
        mem[20] = ins(1, 4, 1, 4, 3);  mem[21] = 32'h2000;
        mem[22] = ins(1, 2, 0, 0, 0);  mem[23] = 32'h40;
        push(8'h01, 0, 0); push(8'h02, 0, 0); push(8'hE0, 0, 1); push(8'h03, 0, 0);
        push(8'hA0, 1, 0);
        for (int k = 1; k < 7; k++) push(8'hA0 + 8'(k), 0, 0);
        for (int k = 0; k < 5; k++) push(8'hB0 + 8'(k), 0, 0);
        for (int k = 0; k < 4; k++) expw(32'h1000 + k, 8'hA0 + 8'(k), 0);
        for (int k = 0; k < 3; k++) expw(32'h2000 + k, 8'hA4 + 8'(k), k == 2);
        gap = 1'b1;
        go(32'h42);
        wait_cyc(120);
        chk(first_rd == 32'h40, "R2 aligned start fetch", first_rd, 32'h40);
        chk(ex_a.size() == 0, "R6/R7 all writes seen", ex_a.size(), 0);
        chk(vq_d.size() == 0, "R4/R8 looped sync drops trailing bytes", vq_d.size(), 0);
        chk(!err, "R3 valid program no error", err, 0);
        stop(); gap = 1'b0;

        // Test B: sync-even, zero count, jump with irq (R5 R8 R10 R12)
        mem[32] = ins(1, 1, 0, 0, 0);  mem[33] = 0;
        mem[34] = ins(1, 3, 1, 0, 0);  mem[35] = 32'h9000;
        mem[36] = ins(1, 3, 0, 0, 2);  mem[37] = 32'h3000;
        mem[38] = ins(1, 2, 1, 0, 0);  mem[39] = 32'h80;
        push(8'h11, 1, 0); push(8'h12, 0, 0); push(8'h21, 0, 1); push(8'h22, 0, 0); push(8'h30, 0, 0);
        expw(32'h3000, 8'h21, 0); expw(32'h3001, 8'h22, 0);
        solo_irq = 2;
        go(32'h80);
        wait_cyc(60);
        chk(ex_a.size() == 0, "R5 even-field writes", ex_a.size(), 0);
        chk(solo_irq == 0, "R12/R10 zero-count and jump irqs", solo_irq, 0);
        chk(vq_d.size() == 0, "R5 bytes dropped while waiting", vq_d.size(), 0);
        stop();

        // Test C: in-line position mismatch (R7 R9 R13)
        mem[48] = ins(1, 3, 0, 0, 2);  mem[49] = 32'h4000;
        mem[50] = ins(1, 4, 0, 5, 1);  mem[51] = 32'h5000;
        push(8'h51, 0, 0); push(8'h52, 0, 0); push(8'h53, 0, 0);
        expw(32'h4000, 8'h51, 0); expw(32'h4001, 8'h52, 0);
        rd_while_err = 0;
        go(32'hC0);
        wait_cyc(30);
        chk(err, "R7 position mismatch halts", err, 1);
        chk(vq_d.size() == 1, "R9 no byte taken after halt", vq_d.size(), 1);
        chk(rd_while_err == 0, "R9 no fetch after halt", rd_while_err, 0);
        chk(ex_a.size() == 0, "R7 line-start writes before halt", ex_a.size(), 0);
        @(negedge clk); run = 1'b0; wait_cyc(2);
        chk(!err && !rd_req, "R13 run low clears error", {err, rd_req}, 0);
        stop();

        // Test D: bit 31 clear (R9)
        mem[56] = ins(0, 3, 0, 0, 1);  mem[57] = 32'h6000;
        push(8'h61, 0, 0);
        go(32'hE0); wait_cyc(15);
        chk(err && vq_d.size() == 1, "R9 invalid bit halts", {err, 8'(vq_d.size())}, {1'b1, 8'd1});
        stop();

        // Test E: undefined opcode 6 (R9)
        mem[58] = ins(1, 6, 0, 0, 1);  mem[59] = 32'h6000;
        go(32'hE8); wait_cyc(15);
        chk(err, "R9 undefined opcode halts", err, 1);
        stop();

        // Test F: abort while syncing (R13)
        go(32'h40); wait_cyc(10);
        chk(vid_ready && !err, "R4 syncing accepts input", {vid_ready, err}, 2'b10);
        @(negedge clk); run = 1'b0; wait_cyc(1);
        chk(!rd_req && !vid_ready && !wr_valid, "R13 abort to idle", {rd_req, vid_ready, wr_valid}, 0);
        wait_cyc(3);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule